// File: doc/BRIEF.md
# Raster scroll and blink window

This block sits on the row-scan side of a dot-matrix display controller. Each cycle it takes the physical scan row being driven and returns the logical display-RAM row to fetch for it. The returned row is the scan row plus a programmable top-raster offset, wrapped at the panel's duty (the number of active rows). Changing that offset scrolls the image vertically. The block also flags rows that fall inside a programmable blink band, and it gives a blanking mask for the off half of the blink phase.

Software programs three 7-bit raster values through a small write port: scroll offset, blink band low edge and blink band high edge. Each value is coded as the intended raster number minus one. Writes land in pending copies. The pending copies and the duty input are committed together on a cycle where `frame_start` is high, so a frame is never drawn with mixed settings. The scan stream is paced by the row counter and cannot be stalled, so there is no valid/ready handshake and no back-pressure. Every output is registered and follows its inputs by exactly one clock. If the committed settings are inconsistent with the committed duty, the block raises an error flag and mutes blinking.

Top module: `raster_window`

## Requirements
- R1: A write with `wr_en` high stores `wr_data[6:0]` into the pending register chosen by `wr_sel`: 0 selects the scroll offset, 1 the blink low edge and 2 the blink high edge. `wr_data[7]` is discarded. `wr_sel` = 3 changes nothing.
- R2: Pending values and the `duty` input become active only on a clock where `frame_start` is high. The row presented in that same cycle already uses them. A write in that same cycle, and any `duty` change without `frame_start`, waits for the next frame start.
- R3: When the active offset is below the active duty, `row_addr` equals (`scan_row` + offset), minus duty if that sum is at least duty. It appears one clock after `scan_row` is presented.
- R4: When the active offset is at or above the active duty, scrolling is bypassed and `row_addr` equals `scan_row` one clock later.
- R5: With a valid configuration, `blink_hit` is high one clock later exactly when blink low ≤ mapped row ≤ blink high, both edges inclusive.
- R6: `blank` equals `blink_hit` AND the `blink_off` value presented in the same cycle as the scan row.
- R7: `cfg_err` is high when any active value (offset, blink low, blink high) is at or above the active duty, or when blink high is not strictly greater than blink low.
- R8: While `cfg_err` is high, `blink_hit` and `blank` are low.
- R9: During reset, all outputs are 0 and every pending and active value, including the duty, is cleared. Until the first frame start after reset, `cfg_err` therefore reads 1 and `row_addr` follows `scan_row`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 offset, 1 blink low, 2 blink high, 3 none |
| wr_data | input | 8 | Write data; bits 6..0 used, bit 7 discarded |
| duty | input | 7 | Number of active panel rows, committed at frame start |
| frame_start | input | 1 | High with the first row of a frame; commits pending settings |
| scan_row | input | 7 | Physical row being scanned |
| blink_off | input | 1 | Blink phase, 1 = off half |
| row_addr | output | 7 | Logical RAM row to fetch |
| blink_hit | output | 1 | Row lies in the blink band |
| blank | output | 1 | Row is to be blanked now |
| cfg_err | output | 1 | Active settings are inconsistent |

## Verification
All four outputs are due exactly one clock after the cycle that presents the scan row, the blink phase and the frame-start strobe. A write changes nothing visible until the row presented with the next frame start. The bench drives every input on the falling edge, waits for the following rising edge plus a small delay, and compares against a reference model. The model applies the commit and the write of that cycle in the same order as R2. To show that deferred writes and duty changes have no effect, the bench scans rows without a frame start after the stimulus and checks that the mapping stays on the old settings.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

  localparam int unsigned RWIN_ROW_W  = 7;
  localparam int unsigned RWIN_DATA_W = 8;
  localparam int unsigned RWIN_NREG   = 3;

  typedef enum logic [1:0] {
    SEL_OFFSET  = 2'd0,
    SEL_BLK_LO  = 2'd1,
    SEL_BLK_HI  = 2'd2,
    SEL_NONE    = 2'd3
  } rwin_sel_e;

endpackage

// File: rtl/rwin_cfg.sv
module rwin_cfg
  import rwin_pkg::*;
#(
  parameter int unsigned ROW_W  = RWIN_ROW_W,
  parameter int unsigned DATA_W = RWIN_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ROW_W-1:0]  duty_in,
  input  logic              commit,
  output logic [ROW_W-1:0]  use_offset,
  output logic [ROW_W-1:0]  use_lo,
  output logic [ROW_W-1:0]  use_hi,
  output logic [ROW_W-1:0]  use_duty,
  output logic              bad_scroll,
  output logic              bad_blink,
  output logic [ROW_W-1:0]  act_duty
);

  localparam int unsigned NREG = RWIN_NREG;

  logic [ROW_W-1:0] pend [NREG];
  logic [ROW_W-1:0] act  [NREG];
  logic [ROW_W-1:0] nx   [NREG];
  logic [ROW_W-1:0] act_duty_q;
  logic [NREG-1:0]  over;

  // pending copies, written from the port; bit 7 of the data is dropped
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) pend[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_sel == 2'(i)) pend[i] <= wr_data[ROW_W-1:0];
      end
    end
  end

  // values seen by this cycle's row: commit picks the pending set
  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_sel
      assign nx[g]   = commit ? pend[g] : act[g];
      assign over[g] = (nx[g] >= use_duty);
    end
  endgenerate

  assign use_duty = commit ? duty_in : act_duty_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) act[i] <= '0;
      act_duty_q <= '0;
    end else if (commit) begin
      for (int i = 0; i < NREG; i++) act[i] <= pend[i];
      act_duty_q <= duty_in;
    end
  end

  assign use_offset = nx[SEL_OFFSET];
  assign use_lo     = nx[SEL_BLK_LO];
  assign use_hi     = nx[SEL_BLK_HI];
  assign bad_scroll = over[SEL_OFFSET];
  assign bad_blink  = over[SEL_BLK_LO] | over[SEL_BLK_HI] |
                      (nx[SEL_BLK_HI] <= nx[SEL_BLK_LO]);
  assign act_duty   = act_duty_q;

endmodule

// File: rtl/rwin_rowmap.sv
module rwin_rowmap #(
  parameter int unsigned ROW_W = 7
) (
  input  logic [ROW_W-1:0] scan_row,
  input  logic [ROW_W-1:0] offset,
  input  logic [ROW_W-1:0] duty,
  input  logic             bypass,
  output logic [ROW_W-1:0] row
);

  localparam int unsigned SUM_W = ROW_W + 1;

  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] wrapped;

  // one compare and one subtract: valid because both terms are below duty
  always_comb begin
    sum     = {1'b0, scan_row} + {1'b0, offset};
    wrapped = (sum >= {1'b0, duty}) ? (sum - {1'b0, duty}) : sum;
    row     = bypass ? scan_row : wrapped[ROW_W-1:0];
  end

endmodule

// File: rtl/rwin_band.sv
module rwin_band #(
  parameter int unsigned ROW_W = 7
) (
  input  logic [ROW_W-1:0] row,
  input  logic [ROW_W-1:0] lo,
  input  logic [ROW_W-1:0] hi,
  input  logic             mute,
  input  logic             phase_off,
  output logic             hit,
  output logic             blank
);

  always_comb begin
    hit   = !mute && (row >= lo) && (row <= hi);
    blank = hit && phase_off;
  end

endmodule

// File: rtl/raster_window.sv
module raster_window
  import rwin_pkg::*;
#(
  parameter int unsigned ROW_W  = RWIN_ROW_W,
  parameter int unsigned DATA_W = RWIN_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ROW_W-1:0]  duty,
  input  logic              frame_start,
  input  logic [ROW_W-1:0]  scan_row,
  input  logic              blink_off,
  output logic [ROW_W-1:0]  row_addr,
  output logic              blink_hit,
  output logic              blank,
  output logic              cfg_err
);

  logic [ROW_W-1:0] use_offset, use_lo, use_hi, use_duty, act_duty;
  logic             bad_scroll, bad_blink;
  logic [ROW_W-1:0] row_c;
  logic             hit_c, blank_c;

  rwin_cfg #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .duty_in    (duty),
    .commit     (frame_start),
    .use_offset (use_offset),
    .use_lo     (use_lo),
    .use_hi     (use_hi),
    .use_duty   (use_duty),
    .bad_scroll (bad_scroll),
    .bad_blink  (bad_blink),
    .act_duty   (act_duty)
  );

  rwin_rowmap #(.ROW_W(ROW_W)) u_map (
    .scan_row (scan_row),
    .offset   (use_offset),
    .duty     (use_duty),
    .bypass   (bad_scroll),
    .row      (row_c)
  );

  rwin_band #(.ROW_W(ROW_W)) u_band (
    .row       (row_c),
    .lo        (use_lo),
    .hi        (use_hi),
    .mute      (bad_scroll | bad_blink),
    .phase_off (blink_off),
    .hit       (hit_c),
    .blank     (blank_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_addr  <= '0;
      blink_hit <= 1'b0;
      blank     <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      row_addr  <= row_c;
      blink_hit <= hit_c;
      blank     <= blank_c;
      cfg_err   <= bad_scroll | bad_blink;
    end
  end

endmodule

// File: rtl/rwin_checker.sv
module rwin_checker #(
  parameter int unsigned ROW_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             blink_off,
  input logic [ROW_W-1:0] scan_row,
  input logic [ROW_W-1:0] row_addr,
  input logic             blink_hit,
  input logic             blank,
  input logic             cfg_err,
  input logic [ROW_W-1:0] act_duty
);

  AST_BLANK_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> blink_hit); // R6

  AST_BLANK_FOLLOWS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !blink_off |=> !blank); // R6

  AST_ERR_MUTES_BLINK: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!blink_hit && !blank)); // R8

  AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_duty)); // R2

  AST_ROW_BELOW_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_row < act_duty) && !frame_start |=> (cfg_err || (row_addr < act_duty))); // R3

endmodule

bind raster_window rwin_checker #(.ROW_W(ROW_W)) u_rwin_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .blink_off   (blink_off),
  .scan_row    (scan_row),
  .row_addr    (row_addr),
  .blink_hit   (blink_hit),
  .blank       (blank),
  .cfg_err     (cfg_err),
  .act_duty    (act_duty)
);

// File: tb/tb_raster_window.sv
module tb_raster_window;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [6:0] duty = 7'd0;
  logic       frame_start = 1'b0;
  logic [6:0] scan_row = 7'd0;
  logic       blink_off = 1'b0;
  logic [6:0] row_addr;
  logic       blink_hit, blank, cfg_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  int p_st = 0, p_lo = 0, p_hi = 0;
  int a_st = 0, a_lo = 0, a_hi = 0, a_du = 0;

  always #2 clk = ~clk;

  raster_window dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .duty(duty), .frame_start(frame_start), .scan_row(scan_row), .blink_off(blink_off),
    .row_addr(row_addr), .blink_hit(blink_hit), .blank(blank), .cfg_err(cfg_err)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // one scan cycle: drive on falling edge, sample just after the rising edge
  task automatic cyc(input bit we, input int sel, input int data, input bit fs,
                     input int row, input bit off, input bit chk, input string tag);
    int es, eh, e_row, sum;
    bit e_err, e_hit, bad_s;
    @(negedge clk);
    wr_en = we; wr_sel = 2'(sel); wr_data = 8'(data);
    frame_start = fs; scan_row = 7'(row); blink_off = off;
    @(posedge clk);
    if (fs) begin a_st = p_st; a_lo = p_lo; a_hi = p_hi; a_du = int'(duty); end
    if (we) begin
      if (sel == 0) p_st = data & 8'h7f;
      if (sel == 1) p_lo = data & 8'h7f;
      if (sel == 2) p_hi = data & 8'h7f;
    end
    bad_s = (a_st >= a_du);
    e_err = bad_s || (a_lo >= a_du) || (a_hi >= a_du) || (a_hi <= a_lo);
    sum   = row + a_st;
    e_row = bad_s ? row : ((sum >= a_du) ? sum - a_du : sum);
    e_hit = !e_err && (e_row >= a_lo) && (e_row <= a_hi);
    es = 0; eh = 0;
    #1;
    if (chk) begin
      check(tag, "row_addr", int'(row_addr), e_row);
      check(tag, "blink_hit", int'(blink_hit), int'(e_hit));
      check(tag, "blank", int'(blank), int'(e_hit && off));
      check(tag, "cfg_err", int'(cfg_err), int'(e_err));
    end
  endtask

  task automatic wr(input int sel, input int data);
    cyc(1'b1, sel, data, 1'b0, 0, 1'b0, 1'b0, "");
  endtask

  task automatic frame(input int du, input int off_mask, input string tag);
    duty = 7'(du);
    for (int r = 0; r < du; r++)
      cyc(1'b0, 0, 0, (r == 0), r, ((r >> off_mask) & 1) == 1, 1'b1, tag);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R9", "row_addr@rst", int'(row_addr), 0);
    check("R9", "blink_hit@rst", int'(blink_hit), 0);
    check("R9", "blank@rst", int'(blank), 0);
    check("R9", "cfg_err@rst", int'(cfg_err), 0);
    @(negedge clk); rst_n = 1'b1;
    // no frame start yet: error set, scroll bypassed (R9, R4)
    cyc(1'b0, 0, 0, 1'b0, 5, 1'b1, 1'b1, "R9");
    cyc(1'b0, 0, 0, 1'b0, 11, 1'b0, 1'b1, "R9");
  endtask

  task automatic t_bit7_and_sel3();
    wr(0, 8'h85);        // bit 7 set, stored as 5 (R1)
    wr(1, 8'h03);
    wr(2, 8'h88);        // stored as 8
    wr(3, 8'h0a);        // select 3 discarded (R1)
    frame(20, 1, "R1");
    cyc(1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b1, "R1");
    check("R1", "row of scan0 with offset 5", int'(row_addr), 5);
  endtask

  task automatic t_deferred();
    wr(0, 12);
    duty = 7'd30;        // duty moves without commit (R2)
    for (int r = 0; r < 20; r += 3) cyc(1'b0, 0, 0, 1'b0, r, 1'b0, 1'b1, "R2");
    // commit with a simultaneous write: the write waits (R2)
    duty = 7'd30;
    cyc(1'b1, 0, 2, 1'b1, 0, 1'b0, 1'b1, "R2");
    check("R2", "row at commit", int'(row_addr), 12);
    for (int r = 1; r < 30; r++) cyc(1'b0, 0, 0, 1'b0, r, 1'b0, 1'b1, "R2");
    frame(30, 0, "R2");
  endtask

  task automatic t_scroll();
    wr(1, 0); wr(2, 1);
    wr(0, 0);  frame(16, 2, "R3");
    wr(0, 15); frame(16, 2, "R3");
    wr(0, 7);  frame(16, 2, "R3");
    wr(0, 33); frame(64, 3, "R3");
    wr(0, 126); frame(127, 4, "R3");
  endtask

  task automatic t_blink();
    wr(0, 10); wr(1, 4); wr(2, 9);
    frame(24, 0, "R5");
    frame(24, 1, "R6");
    wr(0, 20); wr(1, 0); wr(2, 23);
    frame(24, 2, "R5");
    wr(0, 3); wr(1, 22); wr(2, 23);
    frame(24, 0, "R6");
  endtask

  task automatic t_errors();
    wr(0, 2); wr(1, 5); wr(2, 5);   frame(12, 0, "R7");  // high == low
    wr(1, 8); wr(2, 6);             frame(12, 0, "R8");  // high < low
    wr(1, 4); wr(2, 12);            frame(12, 1, "R7");  // high == duty
    wr(1, 13); wr(2, 14);           frame(12, 0, "R7");  // low above duty
    wr(0, 12); wr(1, 1); wr(2, 6);  frame(12, 0, "R4");  // offset == duty
    wr(0, 40);                      frame(12, 1, "R4");
    wr(0, 4);                       frame(12, 0, "R5");  // valid again
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_bit7_and_sel3();
    t_deferred();
    t_scroll();
    t_blink();
    t_errors();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule